// File: doc/BRIEF.md
# LED Matrix Status Refresher

This block keeps a snapshot of a small processor's state on view. Four 8x8 LED matrix driver chips sit on one daisy chain, and the block reaches them over three wires: serial data, serial clock and latch. Its inputs are the values to be shown: the clock speed level, the live CPU clock, the program counter, two instruction bytes, five status flags, six general registers, the stack pointer, sixteen RAM bytes and an 8-bit switch word.

After reset the block sends a fixed set of configuration commands to every chip. It then rewrites the display rows without end. Each 64-bit frame carries one 16-bit word for each chip. All four words address the same row number, so one latch pulse updates that row on all four matrices at once. The input values are sampled at the moment a frame is built. A value that changes while a frame is being shifted therefore shows up only in a later frame.

Top module: `matrix_status_refresher`

## Requirements
- R1: While reset is held, `serClk`, `serLatch` and `serData` are low. After reset exactly five configuration frames go out, in this order (register address, data): (9, 0) decode off, (11, 7) scan all eight rows, (10, INTENSITY) brightness, (15, 0) test mode off, (12, 1) normal operation. Each frame carries the same word to all four chips. No configuration frame is sent again.
- R2: A frame is 64 bits, sent MSB first. It holds four 16-bit words of the form {4'b0000, address[3:0], data[7:0]}. The word for matrix 4 (the chip farthest down the chain) goes first and the word for matrix 1 goes last. `serLatch` rises once after the 64th rising edge of `serClk`.
- R3: `serClk` stays high for HALF_DIV system cycles and low for HALF_DIV cycles within a frame. `serData` changes only while `serClk` is low.
- R4: `serLatch` is high for HALF_DIV cycles and is never high at the same time as `serClk`.
- R5: After the configuration frames, the row frames use register addresses 1, 2, …, 8 and then start again at 1.
- R6: In every data byte, bit 7 drives the leftmost LED column. Matrix 1 rows are as follows. Row 1 has bit (7 - speedLevel) set for speed levels 0 to 6 and no such bit for level 7; its bit 0 shows `cpuClk`. Rows 3, 4 and 5 show `pc`, `instrA` and `instrB`. Row 7 is {C, Z, S, V, H, 3'b000}, taken from `flags[4:0]` = {C, Z, S, V, H}. Rows 2, 6 and 8 are zero.
- R7: Matrix 2 rows 1 to 6 show R0 to R5, where R<i> is `gpRegs[8i+7:8i]`. Row 7 is zero. Row 8 shows `stackPtr`.
- R8: Matrix 3 row r shows `ramLow[8(r-1)+7:8(r-1)]`, which is RAM byte 199+r. Matrix 4 rows 1 to 7 show `ramHigh` bytes in the same way (RAM bytes 248 to 254). Matrix 4 row 8 shows `switches`.
- R9: The displayed values are sampled when a frame starts. Input changes made after the first rising edge of `serClk` in a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| speedLevel | input | 3 | Speed level, 0 to 6 valid |
| cpuClk | input | 1 | Live CPU clock level |
| pc | input | 8 | Program counter |
| instrA | input | 8 | First instruction byte |
| instrB | input | 8 | Second instruction byte |
| flags | input | 5 | {C, Z, S, V, H} |
| gpRegs | input | 48 | R0 to R5, R0 in the low byte |
| stackPtr | input | 8 | Stack pointer |
| ramLow | input | 64 | RAM bytes 200 to 207, byte 200 lowest |
| ramHigh | input | 56 | RAM bytes 248 to 254, byte 248 lowest |
| switches | input | 8 | Switch input word |
| serData | output | 1 | Serial data to the chain |
| serClk | output | 1 | Serial clock |
| serLatch | output | 1 | Latch strobe |

## Verification
Two events can land on the same cycle: the sampling of the snapshot inputs, and a change of those same inputs while a frame is in flight. To provoke this, the bench loads fresh random values in the gap after each latch. On every other frame it also scrambles all inputs again after the tenth rising edge of `serClk`. Each received frame is judged against a model built from the values in force before that scramble. This shows that the scramble has no effect on the frame already underway, and the next frame of the same row is expected to carry the newer values.

// File: rtl/matrix_refresh_pkg.sv
package matrix_refresh_pkg;
  localparam int NUM_CHIPS = 4;
  localparam int WORD_W    = 16;
  localparam int FRAME_W   = NUM_CHIPS * WORD_W;
  localparam int NUM_CFG   = 5;
  localparam int NUM_ROWS  = 8;

  typedef enum logic [1:0] {ST_LOAD, ST_SHIFT, ST_LATCH, ST_GAP} refresh_state_t;

  typedef struct packed {
    logic       load;      // capture snapshot into the shift register
    logic       shift;     // advance one bit (at serial clock fall)
    logic       cfgPhase;  // configuration frames still pending
    logic [2:0] slot;      // command index or row index (0-based)
  } refresh_strobe_t;

  function automatic logic [WORD_W-1:0] mkWord(input logic [3:0] addr, input logic [7:0] data);
    return {4'h0, addr, data};
  endfunction
endpackage

// File: rtl/matrix_refresh_ctrl.sv
module matrix_refresh_ctrl
  import matrix_refresh_pkg::*;
#(
  parameter int HALF_DIV = 16
) (
  input  logic            clk,
  input  logic            rstN,
  output refresh_strobe_t strobe,
  output logic            serClk,
  output logic            serLatch
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  refresh_state_t   state;
  logic [DIV_W-1:0] divCnt;
  logic             half;
  logic [BIT_W-1:0] bitCnt;
  logic             cfgPhase;
  logic [2:0]       slot;
  logic             divDone;

  assign divDone = (divCnt == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_LOAD;
      divCnt   <= '0;
      half     <= 1'b0;
      bitCnt   <= '0;
      cfgPhase <= 1'b1;
      slot     <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          state  <= ST_SHIFT;
          divCnt <= '0;
          half   <= 1'b0;
        end
        ST_SHIFT: begin
          if (divDone) begin
            divCnt <= '0;
            half   <= ~half;
            if (half) begin
              if (bitCnt == LAST_BIT) begin
                bitCnt <= '0;
                state  <= ST_LATCH;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_LATCH: begin
          if (divDone) begin
            divCnt <= '0;
            state  <= ST_GAP;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: begin
          if (divDone) begin
            divCnt <= '0;
            state  <= ST_LOAD;
            if (cfgPhase) begin
              if (slot == 3'(NUM_CFG - 1)) begin
                cfgPhase <= 1'b0;
                slot     <= '0;
              end else begin
                slot <= slot + 1'b1;
              end
            end else begin
              slot <= slot + 1'b1;  // 8 rows: wraps naturally
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.load     = (state == ST_LOAD);
    strobe.shift    = (state == ST_SHIFT) && half && divDone && (bitCnt != LAST_BIT);
    strobe.cfgPhase = cfgPhase;
    strobe.slot     = slot;
  end

  assign serClk   = (state == ST_SHIFT) && half;
  assign serLatch = (state == ST_LATCH);

  // R1
  cfg_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgPhase |=> !cfgPhase);

  // R1
  cfg_slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgPhase |-> slot <= 3'(NUM_CFG - 1));

  // R4
  latch_after_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serLatch) |-> $past(serClk));

  // R5
  row_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && divDone && !cfgPhase) |=> slot == $past(slot) + 3'd1);
endmodule

// File: rtl/matrix_refresh_datapath.sv
module matrix_refresh_datapath
  import matrix_refresh_pkg::*;
#(
  parameter int INTENSITY = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  refresh_strobe_t strobe,
  input  logic [2:0]      speedLevel,
  input  logic            cpuClk,
  input  logic [7:0]      pc,
  input  logic [7:0]      instrA,
  input  logic [7:0]      instrB,
  input  logic [4:0]      flags,
  input  logic [47:0]     gpRegs,
  input  logic [7:0]      stackPtr,
  input  logic [63:0]     ramLow,
  input  logic [55:0]     ramHigh,
  input  logic [7:0]      switches,
  output logic            serData
);
  logic [7:0]         rowData [NUM_CHIPS];
  logic [3:0]         cfgAddr;
  logic [7:0]         cfgData;
  logic [3:0]         rowAddr;
  logic [7:0]         speedBar;
  logic [FRAME_W-1:0] frameNext;
  logic [FRAME_W-1:0] shiftReg;

  assign speedBar = (speedLevel == 3'd7) ? 8'h00 : (8'h80 >> speedLevel);
  assign rowAddr  = {1'b0, strobe.slot} + 4'd1;

  always_comb begin
    case (strobe.slot)
      3'd0:    begin cfgAddr = 4'd9;  cfgData = 8'h00; end
      3'd1:    begin cfgAddr = 4'd11; cfgData = 8'h07; end
      3'd2:    begin cfgAddr = 4'd10; cfgData = 8'(INTENSITY); end
      3'd3:    begin cfgAddr = 4'd15; cfgData = 8'h00; end
      default: begin cfgAddr = 4'd12; cfgData = 8'h01; end
    endcase
  end

  // matrix 1: processor control state
  always_comb begin
    case (strobe.slot)
      3'd0:    rowData[0] = speedBar | {7'b0, cpuClk};
      3'd2:    rowData[0] = pc;
      3'd3:    rowData[0] = instrA;
      3'd4:    rowData[0] = instrB;
      3'd6:    rowData[0] = {flags, 3'b000};
      default: rowData[0] = 8'h00;
    endcase
  end

  // matrix 2: register file
  always_comb begin
    case (strobe.slot)
      3'd6:    rowData[1] = 8'h00;
      3'd7:    rowData[1] = stackPtr;
      default: rowData[1] = gpRegs[8*strobe.slot +: 8];
    endcase
  end

  // matrix 3 and 4: memory windows and switches
  assign rowData[2] = ramLow[8*strobe.slot +: 8];
  assign rowData[3] = (strobe.slot == 3'd7) ? switches : ramHigh[8*strobe.slot +: 8];

  for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_word
    assign frameNext[WORD_W*c +: WORD_W] = strobe.cfgPhase ? mkWord(cfgAddr, cfgData)
                                                           : mkWord(rowAddr, rowData[c]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.load) begin
      shiftReg <= frameNext;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
    end
  end

  assign serData = shiftReg[FRAME_W-1];

  // R9
  hold_between_shifts_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || $past(strobe.load) || $past(strobe.shift)) |-> $stable(shiftReg));
endmodule

// File: rtl/matrix_status_refresher.sv
module matrix_status_refresher
  import matrix_refresh_pkg::*;
#(
  parameter int HALF_DIV  = 16,
  parameter int INTENSITY = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  speedLevel,
  input  logic        cpuClk,
  input  logic [7:0]  pc,
  input  logic [7:0]  instrA,
  input  logic [7:0]  instrB,
  input  logic [4:0]  flags,
  input  logic [47:0] gpRegs,
  input  logic [7:0]  stackPtr,
  input  logic [63:0] ramLow,
  input  logic [55:0] ramHigh,
  input  logic [7:0]  switches,
  output logic        serData,
  output logic        serClk,
  output logic        serLatch
);
  refresh_strobe_t strobe;

  matrix_refresh_ctrl #(.HALF_DIV(HALF_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .serClk(serClk), .serLatch(serLatch)
  );

  matrix_refresh_datapath #(.INTENSITY(INTENSITY)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .speedLevel(speedLevel), .cpuClk(cpuClk), .pc(pc), .instrA(instrA), .instrB(instrB),
    .flags(flags), .gpRegs(gpRegs), .stackPtr(stackPtr), .ramLow(ramLow), .ramHigh(ramHigh),
    .switches(switches), .serData(serData)
  );

  // R3
  data_on_low_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serData) |-> !serClk);

  // R4
  latch_clk_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    serLatch |-> !serClk);
endmodule

// File: tb/matrix_status_refresher_tb_top.sv
`timescale 1ns/1ps
module matrix_status_refresher_tb_top;
  localparam int HALF   = 4;
  localparam int INTENS = 5;
  localparam int NFRAMES = 37;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  speedLevel = '0;
  logic        cpuClk = 1'b0;
  logic [7:0]  pc = '0, instrA = '0, instrB = '0, stackPtr = '0, switches = '0;
  logic [4:0]  flags = '0;
  logic [47:0] gpRegs = '0;
  logic [63:0] ramLow = '0;
  logic [55:0] ramHigh = '0;
  logic        serData, serClk, serLatch;

  int checks = 0;
  int fails  = 0;

  // serial receiver model
  logic [63:0] rx = '0;
  int  riseTotal = 0;
  int  goodPeriods = 0;
  int  badTiming = 0;
  time lastRise = 0;
  int  overlapBad = 0;

  always #5 clk = ~clk;

  matrix_status_refresher #(.HALF_DIV(HALF), .INTENSITY(INTENS)) dut_i (
    .clk(clk), .rstN(rstN), .speedLevel(speedLevel), .cpuClk(cpuClk), .pc(pc),
    .instrA(instrA), .instrB(instrB), .flags(flags), .gpRegs(gpRegs), .stackPtr(stackPtr),
    .ramLow(ramLow), .ramHigh(ramHigh), .switches(switches),
    .serData(serData), .serClk(serClk), .serLatch(serLatch)
  );

  always @(posedge serClk) begin
    rx <= {rx[62:0], serData};
    if (riseTotal > 0) begin
      if ($time - lastRise == 2*HALF*10) goodPeriods++;
      else if ($time - lastRise < 2*HALF*10) badTiming++;
    end
    riseTotal++;
    lastRise = $time;
  end

  always @(negedge serClk) if ($time - lastRise != HALF*10) badTiming++;

  always @(negedge clk) if (rstN && serLatch && serClk) overlapBad++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRow(input int chip, input int row);
    logic [7:0] b;
    b = 8'h00;
    case (chip)
      1: case (row)
           1: b = ((speedLevel <= 6) ? (8'd1 << (7 - speedLevel)) : 8'd0) | {7'd0, cpuClk};
           3: b = pc;
           4: b = instrA;
           5: b = instrB;
           7: b = {flags[4], flags[3], flags[2], flags[1], flags[0], 3'b000};
           default: b = 8'h00;
         endcase
      2: if (row <= 6) b = gpRegs[8*(row-1) +: 8]; else if (row == 8) b = stackPtr;
      3: b = ramLow[8*(row-1) +: 8];
      default: b = (row == 8) ? switches : ramHigh[8*(row-1) +: 8];
    endcase
    return b;
  endfunction

  function automatic logic [63:0] expFrame(input int k);
    logic [63:0] f;
    logic [3:0]  a [5] = '{4'd9, 4'd11, 4'd10, 4'd15, 4'd12};
    logic [7:0]  d [5];
    d = '{8'h00, 8'h07, 8'(INTENS), 8'h00, 8'h01};
    f = '0;
    for (int c = 1; c <= 4; c++) begin
      if (k < 5) f[16*(c-1) +: 16] = {4'h0, a[k], d[k]};
      else f[16*(c-1) +: 16] = {4'h0, 4'((k-5)%8 + 1), expRow(c, (k-5)%8 + 1)};
    end
    return f;
  endfunction

  task automatic randomInputs();
    speedLevel = 3'($urandom_range(7));
    cpuClk     = 1'($urandom);
    pc = 8'($urandom); instrA = 8'($urandom); instrB = 8'($urandom);
    flags = 5'($urandom); stackPtr = 8'($urandom); switches = 8'($urandom);
    gpRegs  = {16'($urandom), $urandom};
    ramLow  = {$urandom, $urandom};
    ramHigh = {24'($urandom), $urandom};
  endtask

  task automatic applyInputs(input int k);
    randomInputs();
    if (k == 5) begin speedLevel = 3'd0; cpuClk = 1'b1; end
    if (k == 13) begin speedLevel = 3'd7; cpuClk = 1'b0; end
    if (k == 21) begin
      speedLevel = 3'd6; cpuClk = 1'b1; pc = '1; instrA = '1; instrB = '1; flags = '1;
      gpRegs = '1; stackPtr = '1; ramLow = '1; ramHigh = '1; switches = '1;
    end
    if (k == 29) begin flags = 5'b10100; pc = 8'h00; end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    logic [63:0] expect_;
    int  risesAtLatch;
    time tLatch;
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {61'd0, serClk, serLatch, serData}, 64'd0);
    @(negedge clk) rstN = 1'b1;
    risesAtLatch = 0;
    expect_ = expFrame(0);
    for (int k = 0; k < NFRAMES; k++) begin
      @(posedge serLatch);
      tLatch = $time;
      #1;
      // R2 R5 R6 R7 R8 R9: frame contents; R1 config sequence
      check(k < 5 ? "R1 config frame" : "R2/R5-R9 row frame", rx, expect_);
      // R2 latch after exactly 64 rises
      check("R2 bits per frame", 64'(riseTotal - risesAtLatch), 64'd64);
      risesAtLatch = riseTotal;
      @(negedge serLatch);
      // R4 latch width
      check("R4 latch width", 64'(($time - tLatch) / 10), 64'(HALF));
      @(negedge clk);
      if (k + 1 < NFRAMES) begin
        applyInputs(k + 1);
        expect_ = expFrame(k + 1);
        if ((k % 2) == 1) begin
          repeat (10) @(posedge serClk);
          @(negedge clk);
          randomInputs();  // R9: must not reach the frame in flight
        end
      end
    end
    // R3 serial timing
    check("R3 bad clock phases", 64'(badTiming), 64'd0);
    check("R3 full periods", 64'(goodPeriods), 64'(63 * NFRAMES));
    // R4 exclusivity
    check("R4 latch with clock high", 64'(overlapBad), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule